// File: doc/BRIEF.md
# Double-Buffered Microprogram Launch Unit

This block sits in front of a vector coprocessor. It turns a stream of small commands into microprogram launches and keeps the data-memory pointers that the coprocessor reads when a program starts. Three pointer commands load a base, an offset and an integer-top staging value. Three launch commands start a program: a call at an address, a call that also asks for a prior flush, and a continue that resumes at the current program counter.

A launch is never issued until the coprocessor reports that its flush is done. While the launch waits, the unit shows busy and ignores further commands. When the launch fires, the unit updates its pointers on the same edge that raises the start pulse. The integer top is copied from its staging value. The double-buffered variant also copies the staged top into the live top. It then moves the staged top to the other buffer half by toggling a buffer-select flag. Half A sits at the base, and half B sits at the base plus the offset.

A parameter selects the single-buffered variant. That variant ignores the base and offset commands and keeps the live top and the flag at zero. It also masks the integer top to a narrower width.

Top module: `mlu_launch_unit`

## Requirements
- R1: After reset, busy, start_pulse, start_cont, start_addr, top_o, itop_o and dbf_o are all zero.
- R2: A call command (op 4, or op 5 for call-after-flush) sets start_addr to the 16-bit immediate shifted left by 3 and clears start_cont. start_pulse is high for exactly one cycle per launch.
- R3: A continue command (op 6) raises start_pulse with start_cont high and leaves start_addr unchanged.
- R4: A launch command accepted on an edge sets busy. While flush_done is low the launch is held: busy stays high and no pulse appears. In the cycle after the first edge at which busy and flush_done are both high, start_pulse is high and busy is low.
- R5: On a launch, itop_o takes the staged integer top. The double-buffered variant takes all 10 bits. The single-buffered variant takes only the low 8 bits.
- R6: On a launch of the double-buffered variant, top_o takes the staged top, held as 10 bits.
- R7: On a launch with dbf_o set, the staged top becomes the base and dbf_o clears. On a launch with dbf_o clear, the staged top becomes (base + offset) mod 1024 and dbf_o sets.
- R8: The offset command (op 2) loads the low 10 immediate bits into the offset. It also clears dbf_o and copies the base into the staged top.
- R9: The base command (op 1) loads the low 10 immediate bits into the base. The integer-top command (op 3) loads the low 10 immediate bits into the staged integer top.
- R10: Any command presented while busy is high has no effect.
- R11: In the single-buffered variant, base and offset commands have no effect, and top_o and dbf_o stay zero.
- R12: Op 0 and op 7 have no effect: no pulse, no busy, no pointer change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_valid | input | 1 | Command present this cycle |
| cmd_op | input | 3 | Command code (0 none, 1 base, 2 offset, 3 integer top, 4 call, 5 call after flush, 6 continue, 7 unused) |
| cmd_imm | input | IMM_W (16) | Command immediate |
| flush_done | input | 1 | Coprocessor flush has completed |
| busy | output | 1 | A launch is pending |
| start_pulse | output | 1 | One-cycle program start |
| start_addr | output | IMM_W+3 (19) | Program start address |
| start_cont | output | 1 | The current start resumes rather than jumps |
| top_o | output | PTR_W (10) | Live data-buffer top for the coprocessor |
| itop_o | output | PTR_W (10) | Live integer top for the coprocessor |
| dbf_o | output | 1 | Buffer-half select flag |

## Verification
On every cycle the assertions check several timing and state rules. Start pulses are single-cycle. A pending launch is held while the flush is outstanding and fires in the cycle after flush_done is seen. A continue keeps the old address. The flag flips on each launch, the live top copies the staged top, and the offset command clears the flag. Some results only the bench's scenarios can show. These include the arithmetic of the buffer-half swap with wraparound, the different integer-top masks of the two variants, and whether commands during busy are dropped. Also among them is whether reserved codes or base and offset commands on the single-buffered variant are ignored. For these, the bench compares both variants against a reference model on every clock.

// File: rtl/mlu_pkg.sv
package mlu_pkg;

   typedef enum logic [2:0] {
      OP_NONE  = 3'd0,
      OP_BASE  = 3'd1,
      OP_OFST  = 3'd2,
      OP_ITOPS = 3'd3,
      OP_CALL  = 3'd4,
      OP_CALLF = 3'd5,
      OP_CONT  = 3'd6,
      OP_RSVD  = 3'd7
   } mlu_op_e;

   typedef struct packed {
      logic launch;
      logic cont;
      logic base;
      logic ofst;
      logic itops;
   } mlu_dec_t;

endpackage

// File: rtl/mlu_cmd_decode.sv
module mlu_cmd_decode
   import mlu_pkg::*;
#(
   parameter bit DOUBLE_BUF = 1'b1
) (
   input  logic       cmd_valid,
   input  logic [2:0] cmd_op,
   input  logic       busy,
   output mlu_dec_t   dec
);

   logic    accept;
   mlu_op_e op;

   assign accept = cmd_valid && !busy;
   assign op     = mlu_op_e'(cmd_op);

   always_comb begin
      dec        = '0;
      dec.launch = accept && (op == OP_CALL || op == OP_CALLF || op == OP_CONT);
      dec.cont   = accept && (op == OP_CONT);
      dec.itops  = accept && (op == OP_ITOPS);
   end

   generate
      if (DOUBLE_BUF) begin : g_dbuf_dec
         always_comb begin
            dec_ptr_base = accept && (op == OP_BASE);
            dec_ptr_ofst = accept && (op == OP_OFST);
         end
      end else begin : g_sbuf_dec
         always_comb begin
            dec_ptr_base = 1'b0;
            dec_ptr_ofst = 1'b0;
         end
      end
   endgenerate

   logic dec_ptr_base;
   logic dec_ptr_ofst;

endmodule

// File: rtl/mlu_launch_seq.sv
module mlu_launch_seq #(
   parameter int IMM_W  = 16,
   localparam int ADDR_W = IMM_W + 3
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              dec_launch,
   input  logic              dec_cont,
   input  logic [IMM_W-1:0]  imm,
   input  logic              flush_done,
   output logic              busy,
   output logic              fire,
   output logic              start_pulse,
   output logic [ADDR_W-1:0] start_addr,
   output logic              start_cont
);

   logic              pending;
   logic              pend_cont;
   logic [ADDR_W-1:0] pend_addr;

   assign busy = pending;
   assign fire = pending && flush_done;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         pending     <= 1'b0;
         pend_cont   <= 1'b0;
         pend_addr   <= '0;
         start_pulse <= 1'b0;
         start_addr  <= '0;
         start_cont  <= 1'b0;
      end else begin
         start_pulse <= fire;
         start_cont  <= fire && pend_cont;
         if (fire) begin
            pending <= 1'b0;
            if (!pend_cont) start_addr <= pend_addr;
         end else if (dec_launch) begin
            pending   <= 1'b1;
            pend_cont <= dec_cont;
            pend_addr <= {imm, 3'b000};
         end
      end
   end

   a_r2_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
      start_pulse |=> !start_pulse);

   a_r4_hold_until_flush: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && !flush_done) |=> (busy && !start_pulse));

   a_r4_fire_after_flush: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && flush_done) |=> (start_pulse && !busy));

   a_r3_cont_keeps_addr: assert property (@(posedge clk) disable iff (!rst_n)
      (start_pulse && start_cont) |-> (start_addr == $past(start_addr)));

endmodule

// File: rtl/mlu_ptr_bank.sv
module mlu_ptr_bank #(
   parameter int PTR_W      = 10,
   parameter bit DOUBLE_BUF = 1'b1,
   parameter int SB_ITOP_W  = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             fire,
   input  logic             set_base,
   input  logic             set_ofst,
   input  logic             set_itops,
   input  logic [PTR_W-1:0] imm,
   output logic [PTR_W-1:0] top,
   output logic [PTR_W-1:0] itop,
   output logic             dbf
);

   localparam int ITOP_W = DOUBLE_BUF ? PTR_W : SB_ITOP_W;
   localparam logic [PTR_W-1:0] ITOP_MASK = PTR_W'((1 << ITOP_W) - 1);

   logic [PTR_W-1:0] itops;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         itops <= '0;
         itop  <= '0;
      end else begin
         if (set_itops) itops <= imm;
         if (fire)      itop  <= itops & ITOP_MASK;
      end
   end

   generate
      if (DOUBLE_BUF) begin : g_dbuf
         logic [PTR_W-1:0] base;
         logic [PTR_W-1:0] ofst;
         logic [PTR_W-1:0] tops;
         logic             dbf_q;
         logic [PTR_W-1:0] top_q;

         always_ff @(posedge clk) begin
            if (!rst_n) begin
               base  <= '0;
               ofst  <= '0;
               tops  <= '0;
               dbf_q <= 1'b0;
               top_q <= '0;
            end else if (fire) begin
               top_q <= tops;
               if (dbf_q) begin
                  tops  <= base;
                  dbf_q <= 1'b0;
               end else begin
                  tops  <= base + ofst;
                  dbf_q <= 1'b1;
               end
            end else if (set_ofst) begin
               ofst  <= imm;
               dbf_q <= 1'b0;
               tops  <= base;
            end else if (set_base) begin
               base <= imm;
            end
         end

         assign top = top_q;
         assign dbf = dbf_q;

         a_r7_dbf_flips: assert property (@(posedge clk) disable iff (!rst_n)
            fire |=> (dbf != $past(dbf)));

         a_r6_top_takes_tops: assert property (@(posedge clk) disable iff (!rst_n)
            fire |=> (top == $past(tops)));

         a_r8_offset_resets_half: assert property (@(posedge clk) disable iff (!rst_n)
            set_ofst |=> (!dbf && tops == $past(base)));
      end else begin : g_sbuf
         logic unused_sb;
         assign unused_sb = ^{set_base, set_ofst};
         assign top = '0;
         assign dbf = 1'b0;
      end
   endgenerate

endmodule

// File: rtl/mlu_launch_unit.sv
module mlu_launch_unit
   import mlu_pkg::*;
#(
   parameter int IMM_W      = 16,
   parameter int PTR_W      = 10,
   parameter bit DOUBLE_BUF = 1'b1,
   parameter int SB_ITOP_W  = 8,
   localparam int ADDR_W    = IMM_W + 3
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cmd_valid,
   input  logic [2:0]        cmd_op,
   input  logic [IMM_W-1:0]  cmd_imm,
   input  logic              flush_done,
   output logic              busy,
   output logic              start_pulse,
   output logic [ADDR_W-1:0] start_addr,
   output logic              start_cont,
   output logic [PTR_W-1:0]  top_o,
   output logic [PTR_W-1:0]  itop_o,
   output logic              dbf_o
);

   generate
      if (PTR_W < 1 || PTR_W > IMM_W) begin : g_bad_ptr_w
         $error("PTR_W must lie between 1 and IMM_W");
      end
      if (SB_ITOP_W < 1 || SB_ITOP_W > PTR_W) begin : g_bad_sb_w
         $error("SB_ITOP_W must lie between 1 and PTR_W");
      end
   endgenerate

   mlu_dec_t dec;
   logic     fire;
   logic     set_base;
   logic     set_ofst;

   mlu_cmd_decode #(.DOUBLE_BUF(DOUBLE_BUF)) u_dec (
      .cmd_valid (cmd_valid),
      .cmd_op    (cmd_op),
      .busy      (busy),
      .dec       (dec)
   );

   assign set_base = u_dec.dec_ptr_base;
   assign set_ofst = u_dec.dec_ptr_ofst;

   mlu_launch_seq #(.IMM_W(IMM_W)) u_seq (
      .clk         (clk),
      .rst_n       (rst_n),
      .dec_launch  (dec.launch),
      .dec_cont    (dec.cont),
      .imm         (cmd_imm),
      .flush_done  (flush_done),
      .busy        (busy),
      .fire        (fire),
      .start_pulse (start_pulse),
      .start_addr  (start_addr),
      .start_cont  (start_cont)
   );

   mlu_ptr_bank #(
      .PTR_W      (PTR_W),
      .DOUBLE_BUF (DOUBLE_BUF),
      .SB_ITOP_W  (SB_ITOP_W)
   ) u_ptr (
      .clk       (clk),
      .rst_n     (rst_n),
      .fire      (fire),
      .set_base  (set_base),
      .set_ofst  (set_ofst),
      .set_itops (dec.itops),
      .imm       (cmd_imm[PTR_W-1:0]),
      .top       (top_o),
      .itop      (itop_o),
      .dbf       (dbf_o)
   );

   logic unused_dec;
   assign unused_dec = ^{dec.base, dec.ofst};

endmodule

// File: tb/mlu_launch_unit_tb_top.sv
module mlu_launch_unit_tb_top;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        cmd_valid = 1'b0;
   logic [2:0]  cmd_op = 3'd0;
   logic [15:0] cmd_imm = 16'd0;
   logic        flush_done = 1'b1;

   logic        busy_d, pulse_d, cont_d, dbf_d;
   logic [18:0] addr_d;
   logic [9:0]  top_d, itop_d;
   logic        busy_s, pulse_s, cont_s, dbf_s;
   logic [18:0] addr_s;
   logic [9:0]  top_s, itop_s;

   int checks = 0;
   int fails  = 0;
   bit done   = 1'b0;
   bit started = 1'b0;

   always #5 clk = ~clk;

   mlu_launch_unit #(.DOUBLE_BUF(1'b1)) dut_i (
      .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
      .cmd_imm(cmd_imm), .flush_done(flush_done), .busy(busy_d),
      .start_pulse(pulse_d), .start_addr(addr_d), .start_cont(cont_d),
      .top_o(top_d), .itop_o(itop_d), .dbf_o(dbf_d));

   mlu_launch_unit #(.DOUBLE_BUF(1'b0)) dut_sb_i (
      .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
      .cmd_imm(cmd_imm), .flush_done(flush_done), .busy(busy_s),
      .start_pulse(pulse_s), .start_addr(addr_s), .start_cont(cont_s),
      .top_o(top_s), .itop_o(itop_s), .dbf_o(dbf_s));

   // reference model, index 0 double-buffered, 1 single-buffered
   int m_base[2], m_ofst[2], m_tops[2], m_itops[2];
   int m_top[2], m_itop[2], m_dbf[2], m_pend[2], m_pcont[2], m_paddr[2];
   int m_pulse[2], m_addr[2], m_cont[2];

   always @(posedge clk) begin
      for (int v = 0; v < 2; v++) begin
         if (!rst_n) begin
            m_base[v] = 0; m_ofst[v] = 0; m_tops[v] = 0; m_itops[v] = 0;
            m_top[v] = 0; m_itop[v] = 0; m_dbf[v] = 0; m_pend[v] = 0;
            m_pcont[v] = 0; m_paddr[v] = 0; m_pulse[v] = 0; m_addr[v] = 0;
            m_cont[v] = 0;
         end else begin
            m_pulse[v] = 0;
            m_cont[v]  = 0;
            if (m_pend[v] != 0 && flush_done) begin
               m_pend[v]  = 0;
               m_pulse[v] = 1;
               m_cont[v]  = m_pcont[v];
               if (m_pcont[v] == 0) m_addr[v] = m_paddr[v];
               m_itop[v] = (v == 0) ? m_itops[v] : (m_itops[v] % 256);
               if (v == 0) begin
                  m_top[v] = m_tops[v];
                  if (m_dbf[v] != 0) begin
                     m_tops[v] = m_base[v];
                     m_dbf[v]  = 0;
                  end else begin
                     m_tops[v] = (m_base[v] + m_ofst[v]) % 1024;
                     m_dbf[v]  = 1;
                  end
               end
            end else if (m_pend[v] == 0 && cmd_valid) begin
               case (cmd_op)
                  3'd1: if (v == 0) m_base[v] = cmd_imm % 1024;
                  3'd2: if (v == 0) begin
                     m_ofst[v] = cmd_imm % 1024;
                     m_dbf[v]  = 0;
                     m_tops[v] = m_base[v];
                  end
                  3'd3: m_itops[v] = cmd_imm % 1024;
                  3'd4, 3'd5: begin
                     m_pend[v] = 1; m_pcont[v] = 0; m_paddr[v] = cmd_imm * 8;
                  end
                  3'd6: begin
                     m_pend[v] = 1; m_pcont[v] = 1;
                  end
                  default: ;
               endcase
            end
         end
      end
      started = 1'b1;
   end

   task automatic chk(input string tag, input int act, input int exp);
      checks++;
      if (act != exp) begin
         fails++;
         $display("FAIL %s actual=0x%0h expected=0x%0h at %0t", tag, act, exp, $time);
      end
   endtask

   always @(negedge clk) begin
      if (started && rst_n && !done) begin
         chk("R2 pulse dbuf", int'(pulse_d), m_pulse[0]);
         chk("R2 addr dbuf",  int'(addr_d),  m_addr[0]);
         chk("R3 cont dbuf",  int'(cont_d),  m_cont[0]);
         chk("R4 busy dbuf",  int'(busy_d),  m_pend[0]);
         chk("R6 top dbuf",   int'(top_d),   m_top[0]);
         chk("R5 itop dbuf",  int'(itop_d),  m_itop[0]);
         chk("R7 dbf dbuf",   int'(dbf_d),   m_dbf[0]);
         chk("R2 pulse sbuf", int'(pulse_s), m_pulse[1]);
         chk("R2 addr sbuf",  int'(addr_s),  m_addr[1]);
         chk("R3 cont sbuf",  int'(cont_s),  m_cont[1]);
         chk("R4 busy sbuf",  int'(busy_s),  m_pend[1]);
         chk("R11 top sbuf",  int'(top_s),   m_top[1]);
         chk("R5 itop sbuf",  int'(itop_s),  m_itop[1]);
         chk("R11 dbf sbuf",  int'(dbf_s),   m_dbf[1]);
      end
   end

   task automatic issue(input logic [2:0] op, input logic [15:0] imm);
      @(negedge clk);
      cmd_valid = 1'b1; cmd_op = op; cmd_imm = imm;
      @(negedge clk);
      cmd_valid = 1'b0; cmd_op = 3'd0; cmd_imm = 16'd0;
   endtask

   task automatic wait_pulse(input string tag);
      bit seen = 1'b0;
      for (int i = 0; i < 50 && !seen; i++) begin
         if (pulse_d) seen = 1'b1;
         else @(negedge clk);
      end
      chk(tag, int'(seen), 1);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1 reset state
      chk("R1 busy", int'(busy_d | busy_s), 0);
      chk("R1 pulse", int'(pulse_d | pulse_s), 0);
      chk("R1 addr", int'(addr_d | addr_s), 0);
      chk("R1 top itop", int'(top_d | itop_d | top_s | itop_s), 0);
      chk("R1 dbf cont", int'(dbf_d | dbf_s | cont_d | cont_s), 0);

      // R9 pointer loads with upper immediate bits set
      issue(3'd1, 16'hFBF0);
      issue(3'd2, 16'hFC20);
      issue(3'd3, 16'hFFFF);
      chk("R8 dbf after offset", int'(dbf_d), 0);

      issue(3'd4, 16'h1234);
      wait_pulse("R2 call pulse seen");
      chk("R2 call addr", int'(addr_d), 32'h91A0);
      chk("R2 call not cont", int'(cont_d), 0);
      chk("R9 top is base", int'(top_d), 32'h3F0);
      chk("R5 itop 10 bit", int'(itop_d), 32'h3FF);
      chk("R5 itop 8 bit", int'(itop_s), 32'hFF);
      chk("R7 dbf set", int'(dbf_d), 1);
      chk("R11 sbuf top", int'(top_s), 0);
      chk("R11 sbuf dbf", int'(dbf_s), 0);

      issue(3'd6, 16'h7777);
      wait_pulse("R3 cont pulse seen");
      chk("R3 cont addr kept", int'(addr_d), 32'h91A0);
      chk("R3 cont flag", int'(cont_d), 1);
      chk("R7 top wraps", int'(top_d), 32'h010);
      chk("R7 dbf clear", int'(dbf_d), 0);

      issue(3'd5, 16'h0001);
      wait_pulse("R2 callf pulse seen");
      chk("R2 callf addr", int'(addr_d), 8);
      chk("R7 top back to base", int'(top_d), 32'h3F0);
      @(negedge clk);
      chk("R2 pulse one cycle", int'(pulse_d), 0);

      issue(3'd2, 16'h0005);
      chk("R8 offset clears dbf", int'(dbf_d), 0);

      // R4 hold and R10 ignore
      flush_done = 1'b0;
      issue(3'd4, 16'h0100);
      issue(3'd1, 16'h0055);
      issue(3'd4, 16'h0200);
      repeat (4) @(negedge clk);
      chk("R4 busy held", int'(busy_d), 1);
      chk("R4 no pulse held", int'(pulse_d), 0);
      flush_done = 1'b1;
      @(negedge clk);
      chk("R4 pulse after flush", int'(pulse_d), 1);
      chk("R4 busy cleared", int'(busy_d), 0);
      chk("R10 addr first call", int'(addr_d), 32'h800);
      chk("R8 top equals base", int'(top_d), 32'h3F0);
      issue(3'd2, 16'h0000);
      issue(3'd4, 16'h0000);
      wait_pulse("R10 pulse seen");
      chk("R10 base not changed", int'(top_d), 32'h3F0);

      // R12 unused codes
      issue(3'd7, 16'h0123);
      issue(3'd0, 16'h0456);
      chk("R12 no busy", int'(busy_d | busy_s), 0);
      chk("R12 no pulse", int'(pulse_d | pulse_s), 0);
      issue(3'd2, 16'h0000);
      issue(3'd4, 16'h0000);
      wait_pulse("R12 pulse seen");
      chk("R12 base kept", int'(top_d), 32'h3F0);

      // R11 single-buffered ignores pointer commands
      issue(3'd1, 16'h0111);
      issue(3'd2, 16'h0002);
      issue(3'd4, 16'h0000);
      wait_pulse("R11 pulse seen");
      chk("R11 top zero", int'(top_s), 0);
      chk("R11 dbf zero", int'(dbf_s), 0);

      // mixed traffic against the model
      for (int n = 0; n < 3000; n++) begin
         @(negedge clk);
         cmd_valid  = ($urandom % 3) != 0;
         cmd_op     = 3'($urandom % 8);
         cmd_imm    = 16'($urandom);
         flush_done = ($urandom % 4) != 0;
      end
      @(negedge clk);
      cmd_valid = 1'b0;
      flush_done = 1'b1;
      repeat (4) @(negedge clk);
      done = 1'b1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         done = 1'b1;
         checks++;
         fails++;
         $display("FAIL watchdog expired");
         $display("%0d/%0d checks passed", checks - fails, checks);
         $finish;
      end
   end

endmodule